// File: doc/BRIEF.md
# Exception Entry and Vector Selection

This block handles the entry into an exception on a 64-bit processor control unit. When the pipeline raises an exception strobe, it supplies the exception class, the program counter of the faulting instruction, whether that instruction sat in a branch delay slot, the faulting virtual address and, for translation faults, the error class and the access direction. In a single clock the block updates the exception-level flag, the exception return address, the cause fields and, for translation faults, the address-capture registers. It also produces the handler address the fetch unit must jump to.

The handler address is one of three offsets above the sign-extended kernel base 0xFFFFFFFF80000000. A translation refill normally gets a dedicated entry point. That entry point depends on whether the faulting segment runs with 64-bit addressing. A refill taken while already at exception level, or caused by an entry marked invalid, falls back to the general entry. Bootstrap vectors are not supported: a strobe that arrives with the bootstrap-vector mode bit set is refused and flagged. A separate return strobe clears the exception-level flag.

Top module: `exc_entry`

## Requirements
- R1: After synchronous reset, exl=0, epc and badvaddr are all ones, cause_code=5'h1F, cause_bd=0, cause_ce=0, new_pc_valid=0 and bev_err=0.
- R2: An accepted exception (exc_req=1, bev=0) taken with exl=0 sets exl and writes epc=cur_pc when in_delay=0, with cause_bd=0. The outputs change at the clock edge that samples the strobe.
- R3: An accepted exception with exl=0 and in_delay=1 writes epc=cur_pc-4 and sets cause_bd=1.
- R4: An accepted exception with exl=1 leaves epc and cause_bd unchanged, but still loads cause_code and loads cause_ce from exc_cop.
- R5: Every accepted exception drives new_pc_valid high for exactly the one cycle after the strobe. General exceptions (tlb_fault=0) vector to 0xFFFFFFFF80000180 and take cause_code from exc_code.
- R6: A refill fault (tlb_fault=1 with tlb_err MISS=0 or INVALID=1) vectors to offset 0x180 when exl was already 1 or when tlb_err is INVALID.
- R7: Otherwise a refill vectors to offset 0x080 when the faulting segment uses 64-bit addressing, and to offset 0x000 when it does not. The segment is chosen by fault_va[63:62]: 00 selects mode_ux, 01 selects mode_sx, 11 selects mode_kx, and 10 always counts as 32-bit.
- R8: For translation faults, cause_code is 2 (load) or 3 (store, is_store=1) for MISS or INVALID. It is 1 for MODIFY (tlb_err=2). It is 4 (load) or 5 (store) for BADADDR (tlb_err=3). MODIFY and BADADDR vector to offset 0x180.
- R9: A translation fault loads badvaddr=fault_va, ctx_vpn2=fault_va[31:13], xctx_vpn2=fault_va[39:13], xctx_r=fault_va[63:62], ehi_vpn2=fault_va[39:13] and ehi_r=fault_va[63:62]. A general exception leaves all of these unchanged.
- R10: A strobe with bev=1 is ignored: exl, epc and cause are unchanged and new_pc_valid stays 0. bev_err is 1 for the cycle after the strobe.
- R11: eret_req with no exception strobe clears exl at the next edge. When both strobes arrive together, the exception wins and exl ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | 1 | Exception strobe |
| exc_code | input | 5 | Cause code for general exceptions |
| exc_cop | input | 2 | Coprocessor number for the cause field |
| tlb_fault | input | 1 | Strobe is an address translation fault |
| tlb_err | input | 2 | Translation error class: 0 miss, 1 invalid, 2 modify, 3 bad address |
| is_store | input | 1 | Faulting access was a store |
| cur_pc | input | 64 | PC of the faulting instruction |
| in_delay | input | 1 | Instruction was in a branch delay slot |
| fault_va | input | 64 | Faulting virtual address |
| mode_ux | input | 1 | User segment 64-bit addressing |
| mode_sx | input | 1 | Supervisor segment 64-bit addressing |
| mode_kx | input | 1 | Kernel segment 64-bit addressing |
| bev | input | 1 | Bootstrap vector mode (unsupported) |
| eret_req | input | 1 | Return from exception strobe |
| exl | output | 1 | Exception level flag |
| epc | output | 64 | Exception return address |
| cause_bd | output | 1 | Branch delay flag of cause |
| cause_code | output | 5 | Exception code of cause |
| cause_ce | output | 2 | Coprocessor error field of cause |
| badvaddr | output | 64 | Captured faulting address |
| ctx_vpn2 | output | 19 | Page-pair number in the 32-bit context view |
| xctx_vpn2 | output | 27 | Page-pair number in the 64-bit context view |
| xctx_r | output | 2 | Region bits in the 64-bit context view |
| ehi_vpn2 | output | 27 | Page-pair number in the entry-high view |
| ehi_r | output | 2 | Region bits in the entry-high view |
| new_pc | output | 64 | Handler address |
| new_pc_valid | output | 1 | One-cycle pulse marking a new handler address |
| bev_err | output | 1 | Refused strobe because bootstrap vectors are selected |

## Verification
The assertions check on every cycle the local rules of entry. An accepted strobe always sets exl. A nested entry never touches epc or the delay flag. A delay-slot entry backs epc up by one instruction. A refused bootstrap-mode strobe changes nothing. Address capture happens only on translation faults, and a refill in a 32-bit region lands at offset zero. The full vector choice depends on the combination of prior exception level, error class, address region and the three mode bits, and so does the mapping of error class and direction to a cause code. Only the bench's table of scenarios covers these combinations, together with the exact field slices captured from a known address and the priority between simultaneous exception and return strobes.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [1:0] {
    TERR_MISS    = 2'd0,
    TERR_INVALID = 2'd1,
    TERR_MODIFY  = 2'd2,
    TERR_BADADDR = 2'd3
  } tlb_err_e;

  localparam logic [4:0] CODE_TLB_MOD  = 5'd1;
  localparam logic [4:0] CODE_TLB_LOAD = 5'd2;
  localparam logic [4:0] CODE_TLB_STOR = 5'd3;
  localparam logic [4:0] CODE_ADR_LOAD = 5'd4;
  localparam logic [4:0] CODE_ADR_STOR = 5'd5;

  localparam logic [11:0] OFS_REFILL_32 = 12'h000;
  localparam logic [11:0] OFS_REFILL_64 = 12'h080;
  localparam logic [11:0] OFS_GENERAL   = 12'h180;
endpackage

// File: rtl/exc_code_map.sv
module exc_code_map
  import exc_pkg::*;
(
  input  logic       tlb_fault,
  input  logic [1:0] tlb_err,
  input  logic       is_store,
  input  logic [4:0] exc_code,
  output logic [4:0] code,
  output logic       refill,
  output logic       err_invalid
);
  tlb_err_e err;
  assign err = tlb_err_e'(tlb_err);

  always_comb begin
    code        = exc_code;
    refill      = 1'b0;
    err_invalid = 1'b0;
    if (tlb_fault) begin
      unique case (err)
        TERR_MISS, TERR_INVALID: begin
          code        = is_store ? CODE_TLB_STOR : CODE_TLB_LOAD;
          refill      = 1'b1;
          err_invalid = (err == TERR_INVALID);
        end
        TERR_MODIFY:  code = CODE_TLB_MOD;
        TERR_BADADDR: code = is_store ? CODE_ADR_STOR : CODE_ADR_LOAD;
        default:      code = exc_code;
      endcase
    end
  end
endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
  import exc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            refill,
  input  logic            err_invalid,
  input  logic            old_exl,
  input  logic [1:0]      va_seg,
  input  logic            mode_ux,
  input  logic            mode_sx,
  input  logic            mode_kx,
  output logic [XLEN-1:0] vec
);
  localparam int EXT = XLEN - 32;
  localparam logic [XLEN-1:0] BASE = {{EXT{1'b1}}, 32'h8000_0000};

  logic       seg_wide;
  logic [11:0] ofs;

  always_comb begin
    unique case (va_seg)
      2'b00:   seg_wide = mode_ux;
      2'b01:   seg_wide = mode_sx;
      2'b11:   seg_wide = mode_kx;
      default: seg_wide = 1'b0;
    endcase
  end

  always_comb begin
    if (!refill || old_exl || err_invalid) ofs = OFS_GENERAL;
    else if (seg_wide)                     ofs = OFS_REFILL_64;
    else                                   ofs = OFS_REFILL_32;
  end

  assign vec = BASE | {{(XLEN-12){1'b0}}, ofs};
endmodule

// File: rtl/exc_fault_regs.sv
module exc_fault_regs #(
  parameter int XLEN    = 64,
  parameter int PG_LSB  = 13,
  parameter int CTX_MSB = 31,
  parameter int XCT_MSB = 39
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load,
  input  logic [XLEN-1:0]           va,
  output logic [XLEN-1:0]           badvaddr,
  output logic [CTX_MSB-PG_LSB:0]   ctx_vpn2,
  output logic [XCT_MSB-PG_LSB:0]   xctx_vpn2,
  output logic [1:0]                xctx_r,
  output logic [XCT_MSB-PG_LSB:0]   ehi_vpn2,
  output logic [1:0]                ehi_r
);
  always_ff @(posedge clk) begin
    if (rst) begin
      badvaddr  <= '1;
      ctx_vpn2  <= '0;
      xctx_vpn2 <= '0;
      xctx_r    <= '0;
      ehi_vpn2  <= '0;
      ehi_r     <= '0;
    end else if (load) begin
      badvaddr  <= va;
      ctx_vpn2  <= va[CTX_MSB:PG_LSB];
      xctx_vpn2 <= va[XCT_MSB:PG_LSB];
      xctx_r    <= va[XLEN-1:XLEN-2];
      ehi_vpn2  <= va[XCT_MSB:PG_LSB];
      ehi_r     <= va[XLEN-1:XLEN-2];
    end
  end

  assert_addr_load_R9: assert property (@(posedge clk) disable iff (rst)
    load |=> (badvaddr == $past(va)) && (ehi_r == $past(va[XLEN-1:XLEN-2])));
  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(badvaddr) && $stable(xctx_vpn2) && $stable(ctx_vpn2));
endmodule

// File: rtl/exc_entry.sv
module exc_entry
  import exc_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int PG_LSB  = 13,
  parameter int CTX_MSB = 31,
  parameter int XCT_MSB = 39
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    exc_req,
  input  logic [4:0]              exc_code,
  input  logic [1:0]              exc_cop,
  input  logic                    tlb_fault,
  input  logic [1:0]              tlb_err,
  input  logic                    is_store,
  input  logic [XLEN-1:0]         cur_pc,
  input  logic                    in_delay,
  input  logic [XLEN-1:0]         fault_va,
  input  logic                    mode_ux,
  input  logic                    mode_sx,
  input  logic                    mode_kx,
  input  logic                    bev,
  input  logic                    eret_req,
  output logic                    exl,
  output logic [XLEN-1:0]         epc,
  output logic                    cause_bd,
  output logic [4:0]              cause_code,
  output logic [1:0]              cause_ce,
  output logic [XLEN-1:0]         badvaddr,
  output logic [CTX_MSB-PG_LSB:0] ctx_vpn2,
  output logic [XCT_MSB-PG_LSB:0] xctx_vpn2,
  output logic [1:0]              xctx_r,
  output logic [XCT_MSB-PG_LSB:0] ehi_vpn2,
  output logic [1:0]              ehi_r,
  output logic [XLEN-1:0]         new_pc,
  output logic                    new_pc_valid,
  output logic                    bev_err
);
  localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

  logic            take;
  logic [4:0]      map_code;
  logic            refill;
  logic            err_invalid;
  logic [XLEN-1:0] vec;

  assign take = exc_req && !bev;

  exc_code_map u_map (
    .tlb_fault   (tlb_fault),
    .tlb_err     (tlb_err),
    .is_store    (is_store),
    .exc_code    (exc_code),
    .code        (map_code),
    .refill      (refill),
    .err_invalid (err_invalid)
  );

  exc_vector_sel #(.XLEN(XLEN)) u_vec (
    .refill      (refill),
    .err_invalid (err_invalid),
    .old_exl     (exl),
    .va_seg      (fault_va[XLEN-1:XLEN-2]),
    .mode_ux     (mode_ux),
    .mode_sx     (mode_sx),
    .mode_kx     (mode_kx),
    .vec         (vec)
  );

  exc_fault_regs #(
    .XLEN(XLEN), .PG_LSB(PG_LSB), .CTX_MSB(CTX_MSB), .XCT_MSB(XCT_MSB)
  ) u_addr (
    .clk       (clk),
    .rst       (rst),
    .load      (take && tlb_fault),
    .va        (fault_va),
    .badvaddr  (badvaddr),
    .ctx_vpn2  (ctx_vpn2),
    .xctx_vpn2 (xctx_vpn2),
    .xctx_r    (xctx_r),
    .ehi_vpn2  (ehi_vpn2),
    .ehi_r     (ehi_r)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      exl          <= 1'b0;
      epc          <= '1;
      cause_bd     <= 1'b0;
      cause_code   <= 5'h1F;
      cause_ce     <= 2'd0;
      new_pc       <= '0;
      new_pc_valid <= 1'b0;
      bev_err      <= 1'b0;
    end else begin
      new_pc_valid <= take;
      bev_err      <= exc_req && bev;
      if (take) begin
        if (!exl) begin
          exl      <= 1'b1;
          epc      <= in_delay ? (cur_pc - INSN_BYTES) : cur_pc;
          cause_bd <= in_delay;
        end
        cause_code <= map_code;
        cause_ce   <= exc_cop;
        new_pc     <= vec;
      end else if (eret_req) begin
        exl <= 1'b0;
      end
    end
  end

  assert_exl_set_R2: assert property (@(posedge clk) disable iff (rst)
    take |=> exl);
  assert_delay_epc_R3: assert property (@(posedge clk) disable iff (rst)
    (take && !exl && in_delay) |=> (epc == $past(cur_pc) - INSN_BYTES) && cause_bd);
  assert_nested_keep_R4: assert property (@(posedge clk) disable iff (rst)
    (take && exl) |=> $stable(epc) && $stable(cause_bd));
  assert_pc_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    new_pc_valid |-> $past(take));
  assert_refill32_R7: assert property (@(posedge clk) disable iff (rst)
    (take && tlb_fault && (tlb_err == 2'd0) && !exl && (fault_va[XLEN-1:XLEN-2] == 2'b10))
    |=> (new_pc[11:0] == 12'h000));
  assert_bev_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (exc_req && bev) |=> !new_pc_valid && bev_err && $stable(exl) && $stable(epc));
  assert_eret_clear_R11: assert property (@(posedge clk) disable iff (rst)
    (eret_req && !exc_req) |=> !exl);
endmodule

// File: tb/exc_entry_bench.sv
module exc_entry_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NROWS = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        exc_req = 0, tlb_fault = 0, is_store = 0, in_delay = 0;
  logic [4:0]  exc_code = 0;
  logic [1:0]  exc_cop = 0, tlb_err = 0;
  logic [63:0] cur_pc = 0, fault_va = 0;
  logic        mode_ux = 0, mode_sx = 0, mode_kx = 0, bev = 0, eret_req = 0;
  logic        exl, cause_bd, new_pc_valid, bev_err;
  logic [63:0] epc, badvaddr, new_pc;
  logic [4:0]  cause_code;
  logic [1:0]  cause_ce, xctx_r, ehi_r;
  logic [18:0] ctx_vpn2;
  logic [26:0] xctx_vpn2, ehi_vpn2;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry u_exc_entry (
    .clk(clk), .rst(rst), .exc_req(exc_req), .exc_code(exc_code), .exc_cop(exc_cop),
    .tlb_fault(tlb_fault), .tlb_err(tlb_err), .is_store(is_store), .cur_pc(cur_pc),
    .in_delay(in_delay), .fault_va(fault_va), .mode_ux(mode_ux), .mode_sx(mode_sx),
    .mode_kx(mode_kx), .bev(bev), .eret_req(eret_req), .exl(exl), .epc(epc),
    .cause_bd(cause_bd), .cause_code(cause_code), .cause_ce(cause_ce),
    .badvaddr(badvaddr), .ctx_vpn2(ctx_vpn2), .xctx_vpn2(xctx_vpn2), .xctx_r(xctx_r),
    .ehi_vpn2(ehi_vpn2), .ehi_r(ehi_r), .new_pc(new_pc), .new_pc_valid(new_pc_valid),
    .bev_err(bev_err)
  );

  // row: tlb(1) err(2) store(1) {ux,sx,kx}(3) va_hi(2) pre_exl(1) offset(12) code(5)
  localparam logic [26:0] ROWS [NROWS] = '{
    {1'b0, 2'd0, 1'b0, 3'b111, 2'b00, 1'b0, 12'h180, 5'd8},
    {1'b1, 2'd0, 1'b0, 3'b100, 2'b00, 1'b0, 12'h080, 5'd2},
    {1'b1, 2'd0, 1'b1, 3'b011, 2'b00, 1'b0, 12'h000, 5'd3},
    {1'b1, 2'd0, 1'b0, 3'b010, 2'b01, 1'b0, 12'h080, 5'd2},
    {1'b1, 2'd0, 1'b0, 3'b001, 2'b11, 1'b0, 12'h080, 5'd2},
    {1'b1, 2'd0, 1'b0, 3'b111, 2'b10, 1'b0, 12'h000, 5'd2},
    {1'b1, 2'd1, 1'b0, 3'b100, 2'b00, 1'b0, 12'h180, 5'd2},
    {1'b1, 2'd0, 1'b1, 3'b100, 2'b00, 1'b1, 12'h180, 5'd3},
    {1'b1, 2'd2, 1'b1, 3'b111, 2'b00, 1'b0, 12'h180, 5'd1},
    {1'b1, 2'd3, 1'b0, 3'b111, 2'b00, 1'b0, 12'h180, 5'd4},
    {1'b1, 2'd3, 1'b1, 3'b111, 2'b00, 1'b0, 12'h180, 5'd5},
    {1'b1, 2'd0, 1'b0, 3'b011, 2'b00, 1'b0, 12'h000, 5'd2}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fire(input logic tf, input logic [1:0] er, input logic st,
                      input logic [4:0] code, input logic [1:0] cop,
                      input logic [63:0] pc, input logic dly, input logic [63:0] va);
    @(negedge clk);
    tlb_fault = tf; tlb_err = er; is_store = st; exc_code = code; exc_cop = cop;
    cur_pc = pc; in_delay = dly; fault_va = va; exc_req = 1'b1;
    @(negedge clk);
    exc_req = 1'b0;
  endtask

  task automatic do_eret();
    @(negedge clk); eret_req = 1'b1;
    @(negedge clk); eret_req = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] va;
    logic [4:0]  saved_code;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 exl", {63'd0, exl}, 64'd0);
    check("R1 epc", epc, '1);
    check("R1 badvaddr", badvaddr, '1);
    check("R1 code", {59'd0, cause_code}, 64'h1F);
    check("R1 valid/bev_err", {62'd0, new_pc_valid, bev_err}, 64'd0);

    // table of vector and code cases (R5 R6 R7 R8)
    for (int i = 0; i < NROWS; i++) begin
      logic [26:0] r;
      r = ROWS[i];
      do_eret();
      {mode_ux, mode_sx, mode_kx} = r[22:20];
      if (r[17]) fire(1'b0, 2'd0, 1'b0, 5'd0, 2'd0, 64'h100, 1'b0, 64'h0);
      va = {r[19:18], 62'h0000_0012_3456_6000};
      fire(r[26], r[25:24], r[23], 5'd8, 2'd0, 64'h200, 1'b0, va);
      check($sformatf("R6/R7 vector row %0d", i), new_pc, {32'hFFFF_FFFF, 20'h80000, r[16:5]});
      check($sformatf("R8 code row %0d", i), {59'd0, cause_code}, {59'd0, r[4:0]});
      check($sformatf("R5 valid row %0d", i), {63'd0, new_pc_valid}, 64'd1);
    end
    mode_ux = 0; mode_sx = 0; mode_kx = 0;

    // R2 first entry, not in delay slot
    do_eret();
    fire(1'b0, 2'd0, 1'b0, 5'd10, 2'd1, 64'hFFFF_FFFF_8000_4000, 1'b0, 64'h0);
    check("R2 exl", {63'd0, exl}, 64'd1);
    check("R2 epc", epc, 64'hFFFF_FFFF_8000_4000);
    check("R2 bd", {63'd0, cause_bd}, 64'd0);
    check("R5 ce", {62'd0, cause_ce}, 64'd1);
    @(negedge clk);
    check("R5 pulse ends", {63'd0, new_pc_valid}, 64'd0);

    // R3 delay slot
    do_eret();
    fire(1'b0, 2'd0, 1'b0, 5'd9, 2'd0, 64'h0000_0000_0040_1000, 1'b1, 64'h0);
    check("R3 epc", epc, 64'h0000_0000_0040_0FFC);
    check("R3 bd", {63'd0, cause_bd}, 64'd1);

    // R4 nested entry
    fire(1'b0, 2'd0, 1'b0, 5'd12, 2'd3, 64'h5000, 1'b0, 64'h0);
    check("R4 epc kept", epc, 64'h0000_0000_0040_0FFC);
    check("R4 bd kept", {63'd0, cause_bd}, 64'd1);
    check("R4 code", {59'd0, cause_code}, 64'd12);
    check("R4 ce", {62'd0, cause_ce}, 64'd3);

    // R9 address capture
    do_eret();
    va = 64'hC000_00AB_CDEF_2000;
    fire(1'b1, 2'd0, 1'b0, 5'd0, 2'd0, 64'h300, 1'b0, va);
    check("R9 badvaddr", badvaddr, va);
    check("R9 ctx", {45'd0, ctx_vpn2}, {45'd0, va[31:13]});
    check("R9 xctx", {37'd0, xctx_vpn2}, {37'd0, va[39:13]});
    check("R9 ehi", {37'd0, ehi_vpn2}, {37'd0, va[39:13]});
    check("R9 regions", {60'd0, xctx_r, ehi_r}, {60'd0, 4'b1111});
    fire(1'b0, 2'd0, 1'b0, 5'd8, 2'd0, 64'h400, 1'b0, 64'h1111_2222_3333_4444);
    check("R9 general keeps badvaddr", badvaddr, va);
    check("R9 general keeps ehi", {37'd0, ehi_vpn2}, {37'd0, va[39:13]});

    // R10 bootstrap mode refused
    do_eret();
    saved_code = cause_code;
    @(negedge clk);
    bev = 1'b1;
    fire(1'b0, 2'd0, 1'b0, 5'd13, 2'd2, 64'h500, 1'b0, 64'h0);
    bev = 1'b0;
    check("R10 exl", {63'd0, exl}, 64'd0);
    check("R10 valid", {63'd0, new_pc_valid}, 64'd0);
    check("R10 bev_err", {63'd0, bev_err}, 64'd1);
    check("R10 code kept", {59'd0, cause_code}, {59'd0, saved_code});

    // R11 return and priority
    fire(1'b0, 2'd0, 1'b0, 5'd8, 2'd0, 64'h600, 1'b0, 64'h0);
    do_eret();
    check("R11 eret clears", {63'd0, exl}, 64'd0);
    @(negedge clk);
    exc_req = 1'b1; eret_req = 1'b1; tlb_fault = 1'b0;
    @(negedge clk);
    exc_req = 1'b0; eret_req = 1'b0;
    check("R11 exception wins", {63'd0, exl}, 64'd1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule